// File: doc/BRIEF.md
# NAND-Style Multiplexed Bus Slave for SRAM Storage

This block sits on the device side of an asynchronous NAND-style host bus and turns that bus traffic into word accesses on an internal SRAM array. The host shares one data bus for commands, addresses and data. Five strobes mark what each cycle carries: a chip-enable, a command latch, an address latch, a write strobe and a read strobe. The block brings each strobe into its own clock domain, classifies every bus cycle, and runs a small command state machine. A command takes one or two command cycles. A start address takes exactly five address cycles. Data then streams in or out with a pointer that advances on its own.

The data phase is 8 or 16 bits wide, set by a static configuration input. Commands and addresses always use the low byte only. The block drives a ready/busy line that drops for a programmable number of cycles after a command that modifies the array has been confirmed. It also returns a status byte that gives the write-protect pin, readiness, nonvolatile-store completion and the pass/fail result of the last command.

Command codes (low byte): 0x00 read setup, 0x30 read confirm, 0x80 program setup, 0x10 program confirm, 0x70 status, 0x59 nonvolatile store, 0xFF reset.

Top module: `nand_sram_slave`

## Requirements
- R1: After reset: rb_n is 1, bus_dq_oe is 0, no mem_wr pulse occurs, and the status byte reads 0xE0 when wp_n is 1.
- R2: A write-strobe rising edge with chip-enable low is classified as a command cycle (cmd latch 1, address latch 0), an address cycle (address latch 1, cmd latch 0) or a data cycle (both 0). A cycle with both latches high, or with chip-enable high, has no effect.
- R3: Five address bytes are taken least significant byte first. Their 40-bit value, truncated to its low ADDR_W bits, becomes the word pointer.
- R4: During command and address cycles, bus_dq_in[15:8] is ignored in every width mode.
- R5: After 0x80 and five address bytes, each data cycle writes one word at the pointer and then increments the pointer. In 16-bit mode the full word is written. In 8-bit mode bits [7:0] are written and the upper byte is written as zero.
- R6: After 0x00, five address bytes and 0x30, each read-strobe falling edge returns the word at the pointer on bus_dq_out and then increments the pointer. In 8-bit mode the upper byte returned is zero.
- R7: After 0x70, each read returns {8'h00, status}. Status bit 7 is wp_n, bit 6 is ready (1 = idle), bit 5 is 1 when no nonvolatile store is pending, bit 0 is fail, and bits 4..1 are zero.
- R8: With wp_n low, 0x80 is rejected. The fail bit is set, and the following address and data cycles write nothing.
- R9: A program confirm (0x10) or a store command (0x59) drives rb_n low for exactly busy_len cycles. Status bit 5 stays 0 from the store command until rb_n returns to 1.
- R10: An unrecognised command byte, including a wrong confirm byte, returns the decoder to idle and sets fail. The next recognised command other than 0x70 clears fail.
- R11: bus_dq_oe is 1 only while the synchronised chip-enable and read strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_x16 | input | 1 | Static data width select: 1 = 16-bit, 0 = 8-bit |
| wp_n | input | 1 | Write protect, active low |
| busy_len | input | BUSY_W | Busy duration in clock cycles |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_cle | input | 1 | Command latch strobe |
| bus_ale | input | 1 | Address latch strobe |
| bus_we_n | input | 1 | Write strobe, data latched on rising edge |
| bus_re_n | input | 1 | Read strobe, data driven after falling edge |
| bus_dq_in | input | 16 | Shared bus, host to device |
| bus_dq_out | output | 16 | Shared bus, device to host |
| bus_dq_oe | output | 1 | Output enable for bus_dq_out |
| rb_n | output | 1 | Ready (1) / busy (0) |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_wr | output | 1 | SRAM write pulse |
| mem_wdata | output | 16 | SRAM write data |
| mem_rd | output | 1 | SRAM read pulse, data expected one cycle later |
| mem_rdata | input | 16 | SRAM read data |

## Verification
Every strobe edge passes through two synchroniser flops and one edge register before it is classified. A write to the SRAM therefore appears three clocks after the write-strobe rise. Read data reaches bus_dq_out five clocks after the read-strobe fall, and rb_n drops four clocks after the confirming edge. The bench holds each strobe level for at least four clocks and samples read data on a falling clock edge eight clocks after the read strobe fell, which is safely past every latency. The busy window is measured by counting every low rb_n sample over a span much longer than busy_len, so the exact length is checked independently of when it starts.

// File: rtl/nss_pkg.sv
package nss_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_RD_CONF,
        PH_RDATA,
        PH_WDATA,
        PH_STATUS
    } phase_e;

    typedef enum logic {
        OP_RD,
        OP_WR
    } op_e;

    localparam logic [7:0] CMD_RD_SETUP = 8'h00;
    localparam logic [7:0] CMD_RD_GO    = 8'h30;
    localparam logic [7:0] CMD_WR_SETUP = 8'h80;
    localparam logic [7:0] CMD_WR_GO    = 8'h10;
    localparam logic [7:0] CMD_STATUS   = 8'h70;
    localparam logic [7:0] CMD_STORE    = 8'h59;
    localparam logic [7:0] CMD_RESET    = 8'hFF;

    // strobe vector bit positions
    localparam int SB_CE  = 0;
    localparam int SB_CLE = 1;
    localparam int SB_ALE = 2;
    localparam int SB_WE  = 3;
    localparam int SB_RE  = 4;
    localparam int SB_N   = 5;
    localparam logic [SB_N-1:0] SB_IDLE = 5'b11001;
endpackage

// File: rtl/nss_sync.sv
module nss_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic [W-1:0] stg_d;
        if (i == 0) begin : g_first
            assign stg_d = d;
        end else begin : g_next
            assign stg_d = stg_q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[i] <= RST_VAL;
            else        stg_q[i] <= stg_d;
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/nss_busy_timer.sv
module nss_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             busy
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)               cnt_d = len;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/nand_sram_slave.sv
module nand_sram_slave
    import nss_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int ADDR_BYTES  = 5,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_x16,
    input  logic              wp_n,
    input  logic [BUSY_W-1:0] busy_len,
    input  logic              bus_ce_n,
    input  logic              bus_cle,
    input  logic              bus_ale,
    input  logic              bus_we_n,
    input  logic              bus_re_n,
    input  logic [15:0]       bus_dq_in,
    output logic [15:0]       bus_dq_out,
    output logic              bus_dq_oe,
    output logic              rb_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [15:0]       mem_wdata,
    output logic              mem_rd,
    input  logic [15:0]       mem_rdata
);
    localparam int ABITS = 8 * ADDR_BYTES;
    localparam int ACW   = $clog2(ADDR_BYTES + 1);
    localparam logic [ACW-1:0] ALAST = ACW'(ADDR_BYTES - 1);

    typedef struct packed {
        phase_e            phase;
        op_e               op;
        logic [ACW-1:0]    acnt;
        logic [ABITS-1:0]  abuf;
        logic [ADDR_W-1:0] ptr;
        logic [SB_N-1:0]   prev;
        logic              fail;
        logic              store_pend;
        logic              wr;
        logic              rd;
        logic              rd_pend;
        logic [ADDR_W-1:0] maddr;
        logic [15:0]       wdata;
        logic [15:0]       dout;
        logic              oe;
        logic              busy_go;
    } st_t;

    localparam st_t ST_RST = '{
        phase: PH_IDLE, op: OP_RD, acnt: '0, abuf: '0, ptr: '0,
        prev: SB_IDLE, fail: 1'b0, store_pend: 1'b0, wr: 1'b0, rd: 1'b0,
        rd_pend: 1'b0, maddr: '0, wdata: '0, dout: '0, oe: 1'b0, busy_go: 1'b0
    };

    st_t st_d, st_q;

    logic [SB_N-1:0] strb_s;
    logic [15:0]     dq_s;
    logic            busy;

    nss_sync #(.W(SB_N), .STAGES(SYNC_STAGES), .RST_VAL(SB_IDLE)) u_strb_sync (
        .clk(clk), .rst_n(rst_n),
        .d({bus_re_n, bus_we_n, bus_ale, bus_cle, bus_ce_n}),
        .q(strb_s)
    );

    nss_sync #(.W(16), .STAGES(SYNC_STAGES), .RST_VAL(16'h0)) u_dq_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_dq_in), .q(dq_s)
    );

    nss_busy_timer #(.CNT_W(BUSY_W)) u_busy (
        .clk(clk), .rst_n(rst_n), .load(st_q.busy_go), .len(busy_len), .busy(busy)
    );

    // decode of a command byte that opens a new command
    function automatic st_t open_cmd(st_t cur, logic [7:0] code, logic wp_ok);
        st_t r = cur;
        r.acnt = '0;
        case (code)
            CMD_RD_SETUP: begin r.phase = PH_ADDR; r.op = OP_RD; r.fail = 1'b0; end
            CMD_WR_SETUP: begin
                if (wp_ok) begin r.phase = PH_ADDR; r.op = OP_WR; r.fail = 1'b0; end
                else       begin r.phase = PH_IDLE; r.fail = 1'b1; end
            end
            CMD_STATUS:   r.phase = PH_STATUS;
            CMD_STORE:    begin
                r.phase = PH_IDLE; r.fail = 1'b0;
                r.store_pend = 1'b1; r.busy_go = 1'b1;
            end
            CMD_RESET:    begin r.phase = PH_IDLE; r.fail = 1'b0; end
            default:      begin r.phase = PH_IDLE; r.fail = 1'b1; end
        endcase
        return r;
    endfunction

    logic             active, we_rise, re_fall;
    logic             cmd_cyc, adr_cyc, dat_cyc, rd_cyc;
    logic [7:0]       lo_byte;
    logic [7:0]       status;
    logic [ABITS-1:0] abuf_nx;

    always_comb begin
        active  = ~strb_s[SB_CE];
        we_rise = strb_s[SB_WE] & ~st_q.prev[SB_WE];
        re_fall = ~strb_s[SB_RE] & st_q.prev[SB_RE];
        cmd_cyc = active & we_rise &  strb_s[SB_CLE] & ~strb_s[SB_ALE];
        adr_cyc = active & we_rise & ~strb_s[SB_CLE] &  strb_s[SB_ALE];
        dat_cyc = active & we_rise & ~strb_s[SB_CLE] & ~strb_s[SB_ALE];
        rd_cyc  = active & re_fall;
        lo_byte = dq_s[7:0];
        status  = {wp_n, rb_n, ~st_q.store_pend, 4'b0000, st_q.fail};
        abuf_nx = {lo_byte, st_q.abuf[ABITS-1:8]};

        st_d         = st_q;
        st_d.prev    = strb_s;
        st_d.wr      = 1'b0;
        st_d.rd      = 1'b0;
        st_d.busy_go = 1'b0;
        st_d.rd_pend = st_q.rd;
        st_d.oe      = ~strb_s[SB_CE] & ~strb_s[SB_RE];

        if (st_q.rd_pend)
            st_d.dout = cfg_x16 ? mem_rdata : {8'h00, mem_rdata[7:0]};

        if (st_q.store_pend && rb_n && !st_q.busy_go)
            st_d.store_pend = 1'b0;

        if (cmd_cyc) begin
            if (st_q.phase == PH_RD_CONF && lo_byte == CMD_RD_GO) begin
                st_d.phase = PH_RDATA;
            end else if (st_q.phase == PH_WDATA && lo_byte == CMD_WR_GO) begin
                st_d.phase   = PH_IDLE;
                st_d.busy_go = 1'b1;
            end else begin
                st_d = open_cmd(st_d, lo_byte, wp_n);
            end
        end else if (adr_cyc && st_q.phase == PH_ADDR) begin
            st_d.abuf = abuf_nx;
            if (st_q.acnt == ALAST) begin
                st_d.ptr   = abuf_nx[ADDR_W-1:0];
                st_d.phase = (st_q.op == OP_RD) ? PH_RD_CONF : PH_WDATA;
                st_d.acnt  = '0;
            end else begin
                st_d.acnt = st_q.acnt + 1'b1;
            end
        end else if (dat_cyc && st_q.phase == PH_WDATA) begin
            st_d.wr    = 1'b1;
            st_d.maddr = st_q.ptr;
            st_d.wdata = cfg_x16 ? dq_s : {8'h00, dq_s[7:0]};
            st_d.ptr   = st_q.ptr + 1'b1;
        end else if (rd_cyc) begin
            if (st_q.phase == PH_RDATA) begin
                st_d.rd    = 1'b1;
                st_d.maddr = st_q.ptr;
                st_d.ptr   = st_q.ptr + 1'b1;
            end else if (st_q.phase == PH_STATUS) begin
                st_d.dout = {8'h00, status};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign rb_n       = ~busy;
    assign bus_dq_out = st_q.dout;
    assign bus_dq_oe  = st_q.oe;
    assign mem_addr   = st_q.maddr;
    assign mem_wr     = st_q.wr;
    assign mem_wdata  = st_q.wdata;
    assign mem_rd     = st_q.rd;
endmodule

// File: rtl/nss_checker.sv
module nss_checker #(
    parameter int BUSY_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_wr,
    input logic              mem_rd,
    input logic              dq_oe,
    input logic              rb_n,
    input logic [BUSY_W-1:0] busy_len,
    input logic              ce_lvl,
    input logic              re_lvl
);
    AST_WR_GATED_CE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(!ce_lvl)); // R2

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr); // R5

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd)); // R5

    AST_RD_AFTER_RE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(!re_lvl && !ce_lvl)); // R6

    AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!ce_lvl && !re_lvl)); // R11

    AST_BUSY_NEEDS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rb_n) |-> ($past(busy_len) != '0)); // R9
endmodule

bind nand_sram_slave nss_checker #(.BUSY_W(BUSY_W)) u_nss_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_wr   (mem_wr),
    .mem_rd   (mem_rd),
    .dq_oe    (bus_dq_oe),
    .rb_n     (rb_n),
    .busy_len (busy_len),
    .ce_lvl   (strb_s[0]),
    .re_lvl   (strb_s[4])
);

// File: tb/nand_sram_slave_tb_top.sv
`timescale 1ns/1ps
module nand_sram_slave_tb_top;
    localparam int AW = 10;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_x16 = 1'b1;
    logic          wp_n = 1'b1;
    logic [BW-1:0] busy_len = 8'd6;
    logic          ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, re_n = 1'b1;
    logic [15:0]   dq_in = 16'h0;
    logic [15:0]   dq_out;
    logic          dq_oe, rb_n;
    logic [AW-1:0] mem_addr;
    logic          mem_wr, mem_rd;
    logic [15:0]   mem_wdata;
    logic [15:0]   mem_rdata = 16'h0;

    logic [15:0] mem_m [1 << AW];
    int n_cmp = 0, n_bad = 0, wr_cnt = 0, busy_cnt = 0;
    logic [15:0] rd_val;
    logic        rd_oe;

    always #10 clk = ~clk;

    nand_sram_slave #(.ADDR_W(AW), .BUSY_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_x16(cfg_x16), .wp_n(wp_n), .busy_len(busy_len),
        .bus_ce_n(ce_n), .bus_cle(cle), .bus_ale(ale), .bus_we_n(we_n), .bus_re_n(re_n),
        .bus_dq_in(dq_in), .bus_dq_out(dq_out), .bus_dq_oe(dq_oe), .rb_n(rb_n),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_rdata(mem_rdata)
    );

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem_m[i] = 16'h0;
    end

    always @(posedge clk) begin
        if (mem_wr) begin mem_m[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
        if (mem_rd) mem_rdata <= mem_m[mem_addr];
    end

    always @(negedge clk) if (rst_n && !rb_n) busy_cnt <= busy_cnt + 1;

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic we_cycle(input logic ce_v, input logic cle_v, input logic ale_v,
                            input logic [15:0] v);
        @(negedge clk);
        ce_n = ce_v; cle = cle_v; ale = ale_v; dq_in = v;
        repeat (2) @(negedge clk);
        we_n = 1'b0;
        repeat (4) @(negedge clk);
        we_n = 1'b1;
        repeat (4) @(negedge clk);
        cle = 1'b0; ale = 1'b0; ce_n = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] c);  we_cycle(1'b0, 1'b1, 1'b0, {8'hC3, c}); endtask
    task automatic adr(input logic [7:0] a);  we_cycle(1'b0, 1'b0, 1'b1, {8'h5A, a}); endtask
    task automatic dat(input logic [15:0] d); we_cycle(1'b0, 1'b0, 1'b0, d); endtask

    task automatic addr5(input logic [7:0] a0, input logic [7:0] a1);
        adr(a0); adr(a1); adr(8'h00); adr(8'h00); adr(8'h00);
    endtask

    task automatic rd();
        @(negedge clk);
        re_n = 1'b0;
        repeat (8) @(negedge clk);
        rd_val = dq_out; rd_oe = dq_oe;
        re_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic status_is(input logic [15:0] exp, input string req);
        cmd(8'h70); rd();
        check(rd_val == exp, req, {16'h0, rd_val}, {16'h0, exp});
    endtask

    // kind: 0 cmd, 1 addr, 2 data, 3 read data, 4 wait ready, 5 read status
    localparam int NV = 22;
    localparam logic [35:0] VEC [NV] = '{
        {4'd0, 16'hEEFF, 16'h0},    // reset cmd, upper byte junk (R4)
        {4'd0, 16'hEE80, 16'h0},    // program setup
        {4'd1, 16'h9934, 16'h0},    // address LSB first (R3)
        {4'd1, 16'h9906, 16'h0},
        {4'd1, 16'h99AA, 16'h0},
        {4'd1, 16'h99BB, 16'h0},
        {4'd1, 16'h99CC, 16'h0},    // ptr = 0x234 after truncation
        {4'd2, 16'hBEEF, 16'h0},    // R5
        {4'd2, 16'h1234, 16'h0},
        {4'd0, 16'h0010, 16'h0},    // confirm
        {4'd4, 16'h0000, 16'h0},
        {4'd0, 16'h7700, 16'h0},    // read setup
        {4'd1, 16'h0034, 16'h0},
        {4'd1, 16'h0002, 16'h0},
        {4'd1, 16'h0000, 16'h0},
        {4'd1, 16'h0000, 16'h0},
        {4'd1, 16'h0000, 16'h0},
        {4'd0, 16'h0030, 16'h0},
        {4'd3, 16'h0000, 16'hBEEF}, // R6
        {4'd3, 16'h0000, 16'h1234},
        {4'd0, 16'h0070, 16'h0},
        {4'd5, 16'h0000, 16'h00E0}  // R7
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int w0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        ce_n = 1'b0;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(rb_n == 1'b1, "R1 rb_n", {31'h0, rb_n}, 32'h1);
        check(dq_oe == 1'b0, "R1 dq_oe", {31'h0, dq_oe}, 32'h0);
        check(wr_cnt == 0, "R1 no writes", wr_cnt, 0);
        status_is(16'h00E0, "R1 status after reset");

        for (int k = 0; k < NV; k++) begin
            logic [3:0]  kd;
            logic [15:0] vv, ee;
            {kd, vv, ee} = VEC[k];
            case (kd)
                4'd0: we_cycle(1'b0, 1'b1, 1'b0, vv);
                4'd1: we_cycle(1'b0, 1'b0, 1'b1, vv);
                4'd2: we_cycle(1'b0, 1'b0, 1'b0, vv);
                4'd4: repeat (busy_len + 10) @(negedge clk);
                default: begin
                    rd();
                    check(rd_val == ee, (kd == 4'd3) ? "R6 table read" : "R7 table status",
                          {16'h0, rd_val}, {16'h0, ee});
                end
            endcase
        end
        // R3 R4: landing address and word content in the memory model
        check(mem_m[10'h234] == 16'hBEEF, "R3 pointer from LSB-first bytes",
              {16'h0, mem_m[10'h234]}, 32'hBEEF);
        check(mem_m[10'h235] == 16'h1234, "R5 pointer increment",
              {16'h0, mem_m[10'h235]}, 32'h1234);
        check(rd_oe == 1'b1, "R11 oe during read", {31'h0, rd_oe}, 32'h1);
        check(dq_oe == 1'b0, "R11 oe idle", {31'h0, dq_oe}, 32'h0);

        // R2: CE high and both-latches-high cycles are ignored
        cmd(8'h80); addr5(8'h00, 8'h01);
        w0 = wr_cnt;
        we_cycle(1'b1, 1'b0, 1'b0, 16'h1111);
        we_cycle(1'b0, 1'b1, 1'b1, 16'h2222);
        check(wr_cnt == w0, "R2 ignored cycles", wr_cnt, w0);
        dat(16'h7777);
        check(mem_m[10'h100] == 16'h7777, "R2 pointer untouched",
              {16'h0, mem_m[10'h100]}, 32'h7777);
        cmd(8'h10);
        repeat (busy_len + 10) @(negedge clk);

        // R11: CE high with RE low keeps the bus released
        @(negedge clk); ce_n = 1'b1; re_n = 1'b0;
        repeat (8) @(negedge clk);
        check(dq_oe == 1'b0, "R11 oe with CE high", {31'h0, dq_oe}, 32'h0);
        re_n = 1'b1; ce_n = 1'b0;
        repeat (4) @(negedge clk);

        // R8: write protect
        wp_n = 1'b0;
        w0 = wr_cnt;
        cmd(8'h80); addr5(8'h20, 8'h00); dat(16'hDEAD);
        check(wr_cnt == w0, "R8 no write under protect", wr_cnt, w0);
        status_is(16'h0061, "R8 status fail and protect");
        wp_n = 1'b1;
        cmd(8'hFF);
        status_is(16'h00E0, "R10 fail cleared by reset cmd");

        // R10: unknown command and wrong confirm
        cmd(8'h42);
        status_is(16'h00E1, "R10 unknown code");
        cmd(8'h00); addr5(8'h34, 8'h02); cmd(8'h31);
        status_is(16'h00E1, "R10 wrong confirm");
        cmd(8'hFF);

        // R9: store, busy length and store-pending bit
        busy_len = 8'd40;
        busy_cnt = 0;
        cmd(8'h59);
        status_is(16'h0080, "R9 status during store");
        repeat (80) @(negedge clk);
        check(busy_cnt == 40, "R9 busy length", busy_cnt, 40);
        status_is(16'h00E0, "R9 status after store");
        busy_len = 8'd6;

        // R5 R6: 8-bit mode
        cfg_x16 = 1'b0;
        cmd(8'h80); addr5(8'h10, 8'h00);
        dat(16'hAB5A); dat(16'hCD3C); cmd(8'h10);
        repeat (20) @(negedge clk);
        check(mem_m[10'h010] == 16'h005A, "R5 x8 write", {16'h0, mem_m[10'h010]}, 32'h005A);
        check(mem_m[10'h011] == 16'h003C, "R5 x8 second write",
              {16'h0, mem_m[10'h011]}, 32'h003C);
        mem_m[10'h012] = 16'hF00F;
        cmd(8'h00); addr5(8'h12, 8'h00); cmd(8'h30);
        rd();
        check(rd_val == 16'h000F, "R6 x8 read upper zero", {16'h0, rd_val}, 32'h000F);

        summary();
    end
endmodule